// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the pending interrupt flags of a 16-bit timer/counter that has three output compare channels, one input capture channel and overflow detection. The timer datapath reports its events as single-cycle strobes: per-channel compare matches, per-channel forced-compare strobes, capture pin events, counter-at-TOP, counter-at-BOTTOM and counter overflow. The block turns these into sticky flag bits, choosing the event that sets the capture and overflow flags from the current waveform mode.

Software reads the flags as one byte and clears any of them by writing a one to its position. An interrupt controller clears a flag by pulsing that flag's acknowledge line for one cycle when it services the request. Each flag, masked by its own enable bit, drives a level interrupt request. The timer clock is the block clock, so "one timer clock later" means one `clk` edge later.

Flag byte layout, used by reads, write-one-to-clear, acknowledge lines, enables and requests alike: bit 0 compare A, bit 1 compare B, bit 2 compare C, bit 3 overflow, bit 4 capture, bits 7:5 reserved.

Top module: `tmr_irq_flags`

## Requirements
- R1: After reset, every bit of the flag byte and every interrupt request is zero.
- R2: A compare match strobe on channel A, B or C (flag bits 0, 1, 2) sets that channel's flag on the second rising edge after the strobe is sampled, one timer clock later than an overflow or capture event would set its flag. After the first edge the flag still reads zero.
- R3: A compare match strobe that arrives together with the same channel's forced-compare strobe does not set that channel's flag. A forced-compare strobe alone does not set it either.
- R4: With the capture-register-as-TOP input low, a capture pin event sets the capture flag (bit 4) on the next edge, and counter-at-TOP does not. With that input high, counter-at-TOP sets the capture flag and a capture pin event does not.
- R5: The overflow flag (bit 3) is set on the next edge by the overflow strobe in mode 0 (normal) and in mode 1 (clear on compare), by counter-at-TOP in mode 2 (fast PWM), and by counter-at-BOTTOM in mode 3 (phase-correct PWM). In any mode, the strobes that do not belong to that mode have no effect on it.
- R6: A bus write clears on the next edge every flag whose bit is written as one. Flags whose bit is written as zero stay as they were.
- R7: A one-cycle acknowledge pulse on a flag's line clears that flag on the next edge.
- R8: When a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up set.
- R9: Bits 7:5 of the flag byte always read zero. Writing ones to them has no effect.
- R10: Each interrupt request output is high exactly when its flag is set and its enable bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and timer clock |
| rstN | input | 1 | Active-low asynchronous reset |
| waveMode | input | 2 | Decoded waveform mode: 0 normal, 1 clear on compare, 2 fast PWM, 3 phase-correct PWM |
| topIsCapReg | input | 1 | High when the mode uses the capture register as TOP |
| cmpMatch | input | 3 | Compare match strobes for channels A, B, C |
| forceCmp | input | 3 | Forced-compare strobes for channels A, B, C |
| capEvent | input | 1 | Capture pin event strobe |
| cntAtTop | input | 1 | Counter has reached TOP |
| cntAtBottom | input | 1 | Counter has reached BOTTOM |
| ovfEvent | input | 1 | Counter overflow strobe |
| wrEn | input | 1 | Bus write strobe for the flag byte |
| wrData | input | 8 | Bus write data; a one clears the flag at that position |
| ackPulse | input | 5 | Per-flag acknowledge pulses from the interrupt controller |
| irqEn | input | 5 | Per-flag interrupt enable bits |
| flagByte | output | 8 | Flag byte for reads |
| irqReq | output | 5 | Level interrupt requests, one per flag |

## Verification
Overflow, capture and clear events show up in the flag byte one edge after they are sampled. Compare matches show up two edges after. Interrupt requests follow the flags and the enables with no added delay. The bench changes inputs on the falling edge and reads outputs on a later falling edge. For a compare it reads once after one rising edge, expecting zero, and again after the second, expecting the flag. Other events are read after a single rising edge, and enable-only changes are read in the same half cycle.

// File: rtl/tmr_irq_flags_pkg.sv
package tmr_irq_flags_pkg;

  localparam int CMP_CH  = 3;
  localparam int FLAG_N  = CMP_CH + 2;
  localparam int OVF_IDX = CMP_CH;
  localparam int CAP_IDX = CMP_CH + 1;

  typedef enum logic [1:0] {
    WAVE_NORMAL = 2'd0,
    WAVE_CTC    = 2'd1,
    WAVE_FAST   = 2'd2,
    WAVE_PHASE  = 2'd3
  } waveMode_t;

  typedef struct packed {
    logic [FLAG_N-1:0] setVec;
    logic [FLAG_N-1:0] clrVec;
  } flagCtl_t;

endpackage

// File: rtl/tmr_irq_flags_ctrl.sv
module tmr_irq_flags_ctrl
  import tmr_irq_flags_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  waveMode_t             waveMode,
  input  logic                  topIsCapReg,
  input  logic [CMP_CH-1:0]     cmpMatch,
  input  logic [CMP_CH-1:0]     forceCmp,
  input  logic                  capEvent,
  input  logic                  cntAtTop,
  input  logic                  cntAtBottom,
  input  logic                  ovfEvent,
  input  logic                  wrEn,
  input  logic [FLAG_N-1:0]     wrBits,
  input  logic [FLAG_N-1:0]     ackPulse,
  output flagCtl_t              ctl
);

  logic [CMP_CH-1:0] cmpDly;
  logic              ovfSrc;
  logic              capSrc;

  // Compare flags lag the match by one timer clock; forced strobes are dropped.
  genvar ch;
  generate
    for (ch = 0; ch < CMP_CH; ch++) begin : gCmp
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cmpDly[ch] <= 1'b0;
        else       cmpDly[ch] <= cmpMatch[ch] & ~forceCmp[ch];
      end

      assert_force_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
        forceCmp[ch] |=> !ctl.setVec[ch]);
    end
  endgenerate

  always_comb begin
    unique case (waveMode)
      WAVE_NORMAL, WAVE_CTC: ovfSrc = ovfEvent;
      WAVE_FAST:             ovfSrc = cntAtTop;
      WAVE_PHASE:            ovfSrc = cntAtBottom;
      default:               ovfSrc = 1'b0;
    endcase
  end

  assign capSrc = topIsCapReg ? cntAtTop : capEvent;

  always_comb begin
    ctl.setVec          = '0;
    ctl.setVec[CMP_CH-1:0] = cmpDly;
    ctl.setVec[OVF_IDX] = ovfSrc;
    ctl.setVec[CAP_IDX] = capSrc;
    ctl.clrVec          = ackPulse | (wrEn ? wrBits : '0);
  end

endmodule

// File: rtl/tmr_irq_flags_dp.sv
module tmr_irq_flags_dp
  import tmr_irq_flags_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  flagCtl_t          ctl,
  input  logic [FLAG_N-1:0] irqEn,
  output logic [BUS_W-1:0]  flagByte,
  output logic [FLAG_N-1:0] irqReq
);

  logic [FLAG_N-1:0] flags;

  genvar fi;
  generate
    for (fi = 0; fi < FLAG_N; fi++) begin : gFlag
      // Set has priority over clear so that no event is lost.
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  flags[fi] <= 1'b0;
        else if (ctl.setVec[fi])    flags[fi] <= 1'b1;
        else if (ctl.clrVec[fi])    flags[fi] <= 1'b0;
      end

      assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rstN)
        ctl.setVec[fi] |=> flags[fi]);
      assert_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
        (ctl.clrVec[fi] && !ctl.setVec[fi]) |=> !flags[fi]);
      assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
        irqReq[fi] |-> (irqEn[fi] && flagByte[fi]));
    end
  endgenerate

  always_comb begin
    flagByte             = '0;
    flagByte[FLAG_N-1:0] = flags;
  end

  assign irqReq = flags & irqEn;

  always_comb begin
    assert_reserved_zero_R9: assert (flagByte[BUS_W-1:FLAG_N] == '0);
  end

endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags
  import tmr_irq_flags_pkg::*;
#(
  parameter int BUS_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [1:0]            waveMode,
  input  logic                  topIsCapReg,
  input  logic [CMP_CH-1:0]     cmpMatch,
  input  logic [CMP_CH-1:0]     forceCmp,
  input  logic                  capEvent,
  input  logic                  cntAtTop,
  input  logic                  cntAtBottom,
  input  logic                  ovfEvent,
  input  logic                  wrEn,
  input  logic [BUS_W-1:0]      wrData,
  input  logic [FLAG_N-1:0]     ackPulse,
  input  logic [FLAG_N-1:0]     irqEn,
  output logic [BUS_W-1:0]      flagByte,
  output logic [FLAG_N-1:0]     irqReq
);

  flagCtl_t ctl;
  logic     unusedWrHi;

  // Reserved write bits reach no logic.
  assign unusedWrHi = ^wrData[BUS_W-1:FLAG_N];

  tmr_irq_flags_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .waveMode    (waveMode_t'(waveMode)),
    .topIsCapReg (topIsCapReg),
    .cmpMatch    (cmpMatch),
    .forceCmp    (forceCmp),
    .capEvent    (capEvent),
    .cntAtTop    (cntAtTop),
    .cntAtBottom (cntAtBottom),
    .ovfEvent    (ovfEvent),
    .wrEn        (wrEn),
    .wrBits      (wrData[FLAG_N-1:0]),
    .ackPulse    (ackPulse),
    .ctl         (ctl)
  );

  tmr_irq_flags_dp #(.BUS_W(BUS_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .irqEn    (irqEn),
    .flagByte (flagByte),
    .irqReq   (irqReq)
  );

  genvar ch;
  generate
    for (ch = 0; ch < CMP_CH; ch++) begin : gChk
      assert_cmp_delay_R2: assert property (@(posedge clk) disable iff (!rstN)
        (cmpMatch[ch] && !forceCmp[ch]) |=> ##1 flagByte[ch]);
    end
  endgenerate

endmodule

// File: tb/tmr_irq_flags_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_flags_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] waveMode = 2'd0;
  logic       topIsCapReg = 1'b0;
  logic [2:0] cmpMatch = '0;
  logic [2:0] forceCmp = '0;
  logic       capEvent = 1'b0;
  logic       cntAtTop = 1'b0;
  logic       cntAtBottom = 1'b0;
  logic       ovfEvent = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [4:0] ackPulse = '0;
  logic [4:0] irqEn = '0;
  logic [7:0] flagByte;
  logic [4:0] irqReq;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tmr_irq_flags dut_i (
    .clk(clk), .rstN(rstN), .waveMode(waveMode), .topIsCapReg(topIsCapReg),
    .cmpMatch(cmpMatch), .forceCmp(forceCmp), .capEvent(capEvent),
    .cntAtTop(cntAtTop), .cntAtBottom(cntAtBottom), .ovfEvent(ovfEvent),
    .wrEn(wrEn), .wrData(wrData), .ackPulse(ackPulse), .irqEn(irqEn),
    .flagByte(flagByte), .irqReq(irqReq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cmpMatch = '0; forceCmp = '0; capEvent = 0; cntAtTop = 0; cntAtBottom = 0;
    ovfEvent = 0; wrEn = 0; wrData = '0; ackPulse = '0;
  endtask

  // Clear everything with a write of all ones.
  task automatic wipe();
    @(negedge clk); idle(); wrEn = 1; wrData = 8'hFF;
    @(negedge clk); idle();
  endtask

  task automatic testReset();
    check("R1 flag byte after reset", flagByte, 8'h00);
    check("R1 requests after reset", {3'b0, irqReq}, 8'h00);
  endtask

  task automatic testCompare();
    for (int ch = 0; ch < 3; ch++) begin
      wipe();
      @(negedge clk); cmpMatch[ch] = 1'b1;
      @(negedge clk); idle();
      check("R2 compare flag not yet set after one edge", flagByte, 8'h00);
      @(negedge clk);
      check("R2 compare flag set after second edge", flagByte, 8'(1 << ch));
    end
  endtask

  task automatic testForce();
    wipe();
    @(negedge clk); cmpMatch = 3'b111; forceCmp = 3'b111;
    @(negedge clk); idle(); forceCmp = 3'b010;
    @(negedge clk); idle();
    @(negedge clk);
    check("R3 forced compare sets no flag", flagByte, 8'h00);
  endtask

  task automatic testCapture();
    wipe();
    @(negedge clk); topIsCapReg = 0; cntAtTop = 1;
    @(negedge clk); idle();
    check("R4 TOP ignored for capture when source is pin", flagByte & 8'h10, 8'h00);
    @(negedge clk); capEvent = 1;
    @(negedge clk); idle();
    check("R4 capture pin sets capture flag", flagByte, 8'h10);
    wipe();
    @(negedge clk); topIsCapReg = 1; capEvent = 1;
    @(negedge clk); idle();
    check("R4 pin ignored when capture register is TOP", flagByte, 8'h00);
    @(negedge clk); cntAtTop = 1;
    @(negedge clk); idle();
    check("R4 TOP sets capture flag", flagByte, 8'h10);
    topIsCapReg = 0;
  endtask

  task automatic testOverflow();
    for (int m = 0; m < 4; m++) begin
      wipe();
      waveMode = 2'(m);
      // Strobes that do not belong to this mode first.
      @(negedge clk);
      ovfEvent    = (m >= 2);
      cntAtTop    = (m != 2);
      cntAtBottom = (m != 3);
      @(negedge clk); idle();
      check("R5 foreign strobes leave overflow clear", flagByte & 8'h08, 8'h00);
      @(negedge clk);
      ovfEvent    = (m < 2);
      cntAtTop    = (m == 2);
      cntAtBottom = (m == 3);
      @(negedge clk); idle();
      check("R5 mode source sets overflow", flagByte & 8'h08, 8'h08);
    end
    waveMode = 2'd0;
  endtask

  task automatic setAll();
    @(negedge clk); cmpMatch = 3'b111; capEvent = 1; ovfEvent = 1;
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  task automatic testWriteClear();
    wipe(); setAll();
    check("R6 all flags set before write", flagByte, 8'h1F);
    @(negedge clk); wrEn = 1; wrData = 8'h00;
    @(negedge clk); idle();
    check("R6 write of zeros keeps flags", flagByte, 8'h1F);
    @(negedge clk); wrEn = 1; wrData = 8'h0A;
    @(negedge clk); idle();
    check("R6 write of ones clears only those bits", flagByte, 8'h15);
  endtask

  task automatic testAck();
    wipe(); setAll();
    @(negedge clk); ackPulse = 5'b10001;
    @(negedge clk); idle();
    check("R7 acknowledge clears its flags", flagByte, 8'h0E);
  endtask

  task automatic testPriority();
    wipe();
    @(negedge clk); ovfEvent = 1; wrEn = 1; wrData = 8'h08;
    @(negedge clk); idle();
    check("R8 set beats write clear", flagByte, 8'h08);
    @(negedge clk); capEvent = 1; ackPulse = 5'b10000;
    @(negedge clk); idle();
    check("R8 set beats acknowledge", flagByte, 8'h18);
  endtask

  task automatic testReserved();
    wipe();
    @(negedge clk); wrEn = 1; wrData = 8'hE0;
    @(negedge clk); idle();
    check("R9 reserved bits read zero after write", flagByte, 8'h00);
  endtask

  task automatic testIrq();
    wipe(); setAll();
    irqEn = 5'b00000;
    #1 check("R10 no request with enables low", {3'b0, irqReq}, 8'h00);
    irqEn = 5'b01101;
    #1 check("R10 requests follow enables", {3'b0, irqReq}, 8'h0D);
    @(negedge clk); ackPulse = 5'b00100;
    @(negedge clk); idle();
    check("R10 request drops with its flag", {3'b0, irqReq}, 8'h09);
    irqEn = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCompare();
    testForce();
    testCapture();
    testOverflow();
    testWriteClear();
    testAck();
    testPriority();
    testReserved();
    testIrq();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule